// File: doc/BRIEF.md
# Grouped Carry Look-Ahead Adder

This block adds two unsigned binary operands and a carry-in. It returns the sum, truncated to the operand width, and the carry-out. It is purely combinational. The operand width is a parameter with a default of 16 bits.

The datapath is cut into 4-bit groups. Each bit first forms a generate term (the AND of the two operand bits) and a propagate term (the inclusive OR of the two operand bits). Inside a group, the carry into every bit position comes straight from a flat two-level sum of products. That sum uses only the group's own generate and propagate terms and the carry entering the group, so no carry ripples inside a group. Carries ripple only between groups: the carry leaving one group is the carry entering the next. With the default width there are four groups, covering bits 3..0, 7..4, 11..8 and 15..12. The carries at bit positions 4, 8 and 12 pass between them, and the carry out of bit 15 is the final carry-out.

Each sum bit is the XOR of the two operand bits and the look-ahead carry into that position. The propagate term is an OR, not an XOR, so it is never reused for the sum.

Top module: `grp_cla_adder`

## Requirements
- R1: `sum_out` equals the low WIDTH bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit WIDTH of `op_a + op_b + carry_in`.
- R3: With `op_a` all ones, `op_b` zero and `carry_in` 1, the carry passes through every group: `sum_out` is 0 and `carry_out` is 1.
- R4: A carry generated in the top bit of one group reaches the lowest bit of the next group. This holds at each boundary: bit 3 into bit 4, bit 7 into bit 8, and bit 11 into bit 12.
- R5: Zero plus zero with `carry_in` 0 gives `sum_out` 0 and `carry_out` 0.
- R6: Where both operand bits are 1, that position still sums correctly. For example, 0xAAAA + 0xAAAA gives 0x5554 with carry-out 1, and 0x5555 + 0x5555 gives 0xAAAA with carry-out 0.
- R7: `carry_in` alone enters bit 0: 0 + 0 + 1 gives `sum_out` 1 and `carry_out` 0.
- R8: Inside a group, a bit whose generate term is 1 forces a carry into the next bit. A bit whose propagate term is 0 forces no carry into the next bit.
- R9: A group whose four bits all propagate and none generate passes its incoming carry unchanged to its outgoing carry. For example, 0x00FF + 0x0001 gives 0x0100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The block has no stored state, so a wrong internal value is a wrong carry term. It shows at the ports in the same evaluation. The sum bit just above the faulty carry flips, and a bad carry between groups can also corrupt every higher group and the carry-out. Carry chains that cross group boundaries, that propagate through whole groups, and that start at both-ones bit positions are therefore the patterns that expose faults. They are driven alongside a large random set, and every result is compared with the arithmetic sum.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
    // bits covered by one flattened look-ahead group
    localparam int GRP_W = 4;

    typedef struct packed {
        logic [GRP_W-1:0] gen;
        logic [GRP_W-1:0] prop;
    } grp_pg_t;
endpackage

// File: rtl/gcla_pg_bits.sv
module gcla_pg_bits #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] gen_out,
    output logic [WIDTH-1:0] prop_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen_out[i]  = a_in[i] & b_in[i];
        assign prop_out[i] = a_in[i] | b_in[i];
    end
endmodule

// File: rtl/gcla_group4.sv
module gcla_group4
    import gcla_pkg::*;
(
    input  grp_pg_t          pg,
    input  logic             c_in,
    output logic [GRP_W-1:0] c_bit,
    output logic             c_out
);
    logic g0, g1, g2, g3, p0, p1, p2, p3;
    logic [GRP_W:1] c_next;

    assign {g3, g2, g1, g0} = pg.gen;
    assign {p3, p2, p1, p0} = pg.prop;

    always_comb begin
        c_next[1] = g0 | (p0 & c_in);
        c_next[2] = g1 | (p1 & g0) | (p1 & p0 & c_in);
        c_next[3] = g2 | (p2 & g1) | (p2 & p1 & g0) | (p2 & p1 & p0 & c_in);
        c_next[4] = g3 | (p3 & g2) | (p3 & p2 & g1) | (p3 & p2 & p1 & g0)
                  | (p3 & p2 & p1 & p0 & c_in);
    end

    assign c_bit = {c_next[3:1], c_in};
    assign c_out = c_next[4];

    always_comb begin
        for (int i = 0; i < GRP_W; i++) begin
            // R8
            gen_forces_carry_chk: assert (!pg.gen[i] || c_next[i+1])
                else $error("generate without carry at group bit %0d", i);
            // R8
            kill_blocks_carry_chk: assert (pg.prop[i] || !c_next[i+1])
                else $error("carry despite zero propagate at group bit %0d", i);
        end
        // R9
        group_pass_through_chk: assert (!((&pg.prop) && !(|pg.gen)) || (c_out == c_in))
            else $error("full-propagate group altered its carry");
    end
endmodule

// File: rtl/gcla_sum_bits.sv
module gcla_sum_bits #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] c_in,
    output logic [WIDTH-1:0] s_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign s_out[i] = a_in[i] ^ b_in[i] ^ c_in[i];
    end
endmodule

// File: rtl/grp_cla_adder.sv
module grp_cla_adder
    import gcla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NGRP = WIDTH / GRP_W;

    logic [WIDTH-1:0] gen_w, prop_w, carry_w;
    logic [NGRP:0]    grp_carry;

    gcla_pg_bits #(.WIDTH(WIDTH)) u_pg (
        .a_in     (op_a),
        .b_in     (op_b),
        .gen_out  (gen_w),
        .prop_out (prop_w)
    );

    assign grp_carry[0] = carry_in;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        grp_pg_t pg_k;
        assign pg_k.gen  = gen_w[k*GRP_W +: GRP_W];
        assign pg_k.prop = prop_w[k*GRP_W +: GRP_W];

        gcla_group4 u_grp (
            .pg    (pg_k),
            .c_in  (grp_carry[k]),
            .c_bit (carry_w[k*GRP_W +: GRP_W]),
            .c_out (grp_carry[k+1])
        );
    end

    gcla_sum_bits #(.WIDTH(WIDTH)) u_sum (
        .a_in  (op_a),
        .b_in  (op_b),
        .c_in  (carry_w),
        .s_out (sum_out)
    );

    assign carry_out = grp_carry[NGRP];

    always_comb begin
        // R1
        sum_matches_chk: assert (sum_out == WIDTH'({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("sum mismatch");
        // R2
        carry_matches_chk: assert (carry_out == 1'(({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}) >> WIDTH))
            else $error("carry-out mismatch");
    end
endmodule

// File: tb/grp_cla_adder_test.sv
module grp_cla_adder_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 16;
    localparam int  WATCHDOG   = 10000;

    typedef struct {
        logic [W:0] exp_val;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    item_t sb_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    bit    done    = 0;

    grp_cla_adder #(.WIDTH(W)) uut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = ci;
        it.exp_val = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // monitor: sample half a period after each drive
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if ({carry_out, sum_out} !== it.exp_val) begin
                n_fail++;
                $display("FAIL %s: got carry=%0b sum=%h, expected carry=%0b sum=%h",
                         it.tag, carry_out, sum_out, it.exp_val[W], it.exp_val[W-1:0]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        drive(16'h0000, 16'h0000, 1'b0, "R5 zero plus zero");
        drive(16'hFFFF, 16'h0000, 1'b1, "R3 all ones plus carry-in");
        drive(16'h0000, 16'h0000, 1'b1, "R7 carry-in alone");
        drive(16'h000F, 16'h0001, 1'b0, "R4 boundary 3->4");
        drive(16'h00F0, 16'h0010, 1'b0, "R4 boundary 7->8");
        drive(16'h0F00, 16'h0100, 1'b0, "R4 boundary 11->12");
        drive(16'hF000, 16'h1000, 1'b0, "R2 carry-out from top group");
        drive(16'hAAAA, 16'hAAAA, 1'b0, "R6 alternating AAAA");
        drive(16'h5555, 16'h5555, 1'b0, "R6 alternating 5555");
        drive(16'hAAAA, 16'h5555, 1'b1, "R3 R9 full propagate with carry-in");
        drive(16'h00FF, 16'h0001, 1'b0, "R9 group pass-through");
        drive(16'h0808, 16'h0808, 1'b0, "R8 generate inside groups");
        drive(16'h7777, 16'h0000, 1'b1, "R8 zero propagate blocks carry");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 max operands");
        for (int i = 0; i < 3000; i++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        finish_run();
    end
endmodule